// File: doc/BRIEF.md
# Serial Addressed Gain-Control Register Bank

This block receives gain settings for an eight-channel programmable amplifier array over a three-wire serial link. The wires are a serial clock, a serial data line and a separate load/latch strobe. Data bits are shifted in, most significant bit first, on rising edges of the serial clock. The last eight bits shifted in form a command word. The word is committed only when the strobe makes its active transition.

In each command word the top bit qualifies the word for this device. The next three bits pick one of eight channels, and the low four bits carry the gain code. A committed word updates only the addressed channel's 4-bit register. A code of zero puts that channel into powersave rather than selecting a gain step. A static polarity input picks which strobe edge is active.

All three serial inputs are treated as asynchronous. They are synchronised into a single system clock domain, and every register runs on that one clock. Setup and hold checking on the serial link is left to the system around the block.

Top module: `gain_cmd_rx`

## Requirements
- R1: On each rising edge of sclk_i the level of sdata_i is shifted into the command word, most significant bit first. Only the last eight bits sampled form the word, and extra leading bits are pushed out.
- R2: With latch_pol_low_i=0 a falling edge of latch_i commits the word and a rising edge does nothing. With latch_pol_low_i=1 a rising edge of latch_i commits the word and a falling edge does nothing.
- R3: A word whose bit 7 is 0 changes no channel register when it is latched.
- R4: Bits 6..4 of a qualified word select channel 0 (000) up to channel 7 (111). That channel's register appears on gain_o[4*ch+3:4*ch].
- R5: On a latch event, the registers of every channel other than the addressed one keep their values.
- R6: After reset all gain codes are 0000, every pwrsave_o bit is 1, and the shift register is cleared, so a strobe with no new bits changes nothing.
- R7: pwrsave_o[ch] is 1 exactly when channel ch holds code 0000.
- R8: gain_o and pwrsave_o change only as the result of a latch event, never while bits are being shifted.
- R9: All sixteen codes (bits 3..0 of the word) are stored unchanged and read back on gain_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| sdata_i | input | 1 | Serial command data, MSB first |
| latch_i | input | 1 | Load/latch strobe (asynchronous) |
| latch_pol_low_i | input | 1 | Static strobe polarity: 0 active high (falling edge commits), 1 active low (rising edge commits) |
| gain_o | output | 32 | Eight 4-bit gain codes, channel ch at bits 4*ch+3..4*ch |
| pwrsave_o | output | 8 | Per-channel powersave flags |

## Verification
The assertions check on every cycle that outputs move only after a latch event and that an unqualified word leaves them unchanged. They also check that at most one channel changes at a time, that the addressed channel takes the latched code, that each powersave flag agrees with its stored code, and that every detected serial clock rise shifts in the synchronised data bit. Some behaviours can only be shown by the bench's scenarios. These are the strobe polarity choice, including the ignored opposite edge, the pushing out of extra leading bits, the cleared shift register after reset, and the full round trip from serial pins to the output for all sixteen codes across random channel patterns.

// File: rtl/gain_cmd_pkg.sv
package gain_cmd_pkg;
  localparam int unsigned NUM_CH      = 8;
  localparam int unsigned CODE_W      = 4;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned ADDR_W      = $clog2(NUM_CH);
  localparam int unsigned WORD_W      = 1 + ADDR_W + CODE_W;
endpackage

// File: rtl/gcr_sync.sv
module gcr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gcr_edge_det.sv
module gcr_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic lvl, prev_q;

  gcr_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(async_i),
    .sync_o (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  assign level_o = lvl;
  assign rise_o  = lvl & ~prev_q;
  assign fall_o  = ~lvl & prev_q;
endmodule

// File: rtl/gcr_shift.sv
module gcr_shift #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] sr_q;

  // MSB first: oldest bit ends at the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[WIDTH-2:0], bit_i};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/gcr_bank.sv
module gcr_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 4,
  localparam int unsigned ADDR_W = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CODE_W-1:0]        code_i,
  output logic [NUM_CH*CODE_W-1:0] gain_o,
  output logic [NUM_CH-1:0]        pwrsave_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    logic              ps_q;
    logic              hit;

    assign hit = we_i && (addr_i == ADDR_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q <= '0;
        ps_q   <= 1'b1;
      end else if (hit) begin
        code_q <= code_i;
        ps_q   <= (code_i == '0);
      end
    end

    assign gain_o[c*CODE_W +: CODE_W] = code_q;
    assign pwrsave_o[c]               = ps_q;
  end
endmodule

// File: rtl/gain_cmd_rx.sv
module gain_cmd_rx
  import gain_cmd_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned C_W    = CODE_W,
  parameter int unsigned N_SYNC = SYNC_STAGES,
  localparam int unsigned A_W   = $clog2(N_CH),
  localparam int unsigned W_W   = 1 + A_W + C_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 sdata_i,
  input  logic                 latch_i,
  input  logic                 latch_pol_low_i,
  output logic [N_CH*C_W-1:0]  gain_o,
  output logic [N_CH-1:0]      pwrsave_o
);
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic lat_lvl, lat_rise, lat_fall;
  logic data_s, latch_evt, commit;
  logic [W_W-1:0] word_q;

  gcr_edge_det #(.STAGES(N_SYNC)) u_sclk_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(sclk_i),
    .level_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  // same depth as clock path keeps data aligned to the detected rise
  gcr_sync #(.STAGES(N_SYNC)) u_data_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(sdata_i), .sync_o(data_s)
  );

  gcr_edge_det #(.STAGES(N_SYNC)) u_lat_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(latch_i),
    .level_o(lat_lvl), .rise_o(lat_rise), .fall_o(lat_fall)
  );

  gcr_shift #(.WIDTH(W_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(sclk_rise),
    .bit_i(data_s), .word_o(word_q)
  );

  assign latch_evt = latch_pol_low_i ? lat_rise : lat_fall;
  assign commit    = latch_evt & word_q[W_W-1];

  gcr_bank #(.NUM_CH(N_CH), .CODE_W(C_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (commit),
    .addr_i   (word_q[C_W +: A_W]),
    .code_i   (word_q[C_W-1:0]),
    .gain_o   (gain_o),
    .pwrsave_o(pwrsave_o)
  );

  logic unused_lvl;
  assign unused_lvl = sclk_lvl ^ sclk_fall ^ lat_lvl;
endmodule

// File: rtl/gain_cmd_rx_chk.sv
module gain_cmd_rx_chk #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned C_W  = 4,
  localparam int unsigned A_W = $clog2(N_CH),
  localparam int unsigned W_W = 1 + A_W + C_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sclk_rise,
  input logic                data_s,
  input logic                latch_evt,
  input logic [W_W-1:0]      word_q,
  input logic [N_CH*C_W-1:0] gain_o,
  input logic [N_CH-1:0]     pwrsave_o
);
  logic [N_CH*C_W-1:0] prev_q;
  logic [N_CH-1:0]     chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= gain_o;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_c
    assign chg[c] = gain_o[c*C_W +: C_W] != prev_q[c*C_W +: C_W];

    // R4: addressed channel takes the code
    a_r4_target_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      latch_evt && word_q[W_W-1] && (word_q[C_W +: A_W] == A_W'(c))
      |=> gain_o[c*C_W +: C_W] == $past(word_q[C_W-1:0]));

    // R7
    a_r7_pwrsave_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwrsave_o[c] == (gain_o[c*C_W +: C_W] == '0));
  end

  // R5
  a_r5_single_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chg) <= 1);

  // R8
  a_r8_hold_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_evt |=> $stable(gain_o) && $stable(pwrsave_o));

  // R3
  a_r3_msb_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_evt && !word_q[W_W-1] |=> $stable(gain_o));

  // R1
  a_r1_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> word_q[0] == $past(data_s));
endmodule

bind gain_cmd_rx gain_cmd_rx_chk #(.N_CH(N_CH), .C_W(C_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sclk_rise(sclk_rise),
  .data_s   (data_s),
  .latch_evt(latch_evt),
  .word_q   (word_q),
  .gain_o   (gain_o),
  .pwrsave_o(pwrsave_o)
);

// File: tb/gain_cmd_rx_test.sv
module gain_cmd_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int CW  = 4;

  logic clk = 0, rst_ni = 0;
  logic sclk = 0, sdata = 0, latch = 0, pol_low = 0;
  logic [NCH*CW-1:0] gain;
  logic [NCH-1:0]    pwrsave;

  int vectors = 0, fails = 0;
  logic [CW-1:0] exp_gain [NCH];
  bit done = 0;

  gain_cmd_rx uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata),
    .latch_i(latch), .latch_pol_low_i(pol_low),
    .gain_o(gain), .pwrsave_o(pwrsave)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mk_word(bit q, int ch, int code);
    return {q, 3'(ch), 4'(code)};
  endfunction

  // model of a latch: only qualified words update one channel
  function automatic void model_latch(logic [7:0] w);
    if (w[7]) exp_gain[w[6:4]] = w[3:0];
  endfunction

  task automatic send_bit(bit b);
    @(negedge clk) sdata = b;
    repeat (2) @(negedge clk);
    sclk = 1;
    repeat (4) @(negedge clk);
    sclk = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(logic [15:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
  endtask

  task automatic pulse_latch();
    repeat (3) @(negedge clk);
    latch = ~latch;
    repeat (4) @(negedge clk);
    latch = ~latch;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    for (int c = 0; c < NCH; c++) begin
      logic [CW-1:0] g;
      g = gain[c*CW +: CW];
      vectors++;
      if (g !== exp_gain[c]) begin
        fails++;
        $display("FAIL %s ch%0d gain act=%h exp=%h", tag, c, g, exp_gain[c]);
      end
      vectors++;
      if (pwrsave[c] !== (exp_gain[c] == 0)) begin
        fails++;
        $display("FAIL R7 %s ch%0d pwrsave act=%b exp=%b", tag, c, pwrsave[c], exp_gain[c] == 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] w;
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < NCH; c++) exp_gain[c] = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    check_all("R6 reset");

    // R6: shift register cleared, strobe with no bits is a non-qualified word
    pulse_latch();
    check_all("R6 cleared shift");

    // R4/R9: each channel, a directed code
    for (int c = 0; c < NCH; c++) begin
      w = mk_word(1, c, 15 - c);
      send_bits({8'h00, w}, 8);
      check_all("R8 before latch");
      pulse_latch();
      model_latch(w);
      check_all("R4 channel select");
    end

    // R3: bit 7 clear ignored
    send_bits({8'h00, mk_word(0, 2, 5)}, 8);
    pulse_latch();
    check_all("R3 unqualified word");

    // R1: extra leading bits pushed out
    w = mk_word(1, 3, 9);
    send_bits({6'b010110, 2'b00, w}, 11);
    pulse_latch();
    model_latch(w);
    check_all("R1 extra bits");

    // R9: all sixteen codes on channel 6, R7 via zero code
    for (int k = 0; k < 16; k++) begin
      w = mk_word(1, 6, k);
      send_bits({8'h00, w}, 8);
      pulse_latch();
      model_latch(w);
      check_all("R9 code sweep");
    end

    // R2 active-high: rising edge alone does nothing
    w = mk_word(1, 1, 4'h3);
    send_bits({8'h00, w}, 8);
    repeat (3) @(negedge clk);
    latch = 1;
    repeat (10) @(negedge clk);
    check_all("R2 rise ignored high mode");
    latch = 0;
    repeat (10) @(negedge clk);
    model_latch(w);
    check_all("R2 fall commits high mode");

    // switch to active-low: raise strobe (inactive rise), then set polarity
    w = mk_word(0, 0, 0);
    send_bits({8'h00, w}, 8);
    latch = 1;
    repeat (10) @(negedge clk);
    pol_low = 1;
    repeat (4) @(negedge clk);
    w = mk_word(1, 5, 4'hc);
    send_bits({8'h00, w}, 8);
    latch = 0;
    repeat (10) @(negedge clk);
    check_all("R2 fall ignored low mode");
    latch = 1;
    repeat (10) @(negedge clk);
    model_latch(w);
    check_all("R2 rise commits low mode");

    // random traffic in low mode, R5: one channel at a time
    for (int n = 0; n < 120; n++) begin
      int extra;
      logic [15:0] bits;
      w = mk_word(($urandom % 8) != 0, $urandom % NCH, $urandom % 16);
      extra = $urandom % 4;
      bits = {8'($urandom), w};
      send_bits(bits, 8 + extra);
      pulse_latch();
      model_latch(w);
      check_all("R5 random");
    end

    // back to active-high: drop strobe (inactive fall in low mode), then flip
    latch = 0;
    repeat (10) @(negedge clk);
    pol_low = 0;
    repeat (4) @(negedge clk);
    for (int n = 0; n < 60; n++) begin
      w = mk_word(($urandom % 8) != 0, $urandom % NCH, $urandom % 16);
      send_bits({8'h00, w}, 8);
      pulse_latch();
      model_latch(w);
      check_all("R4 random high mode");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule